// File: doc/BRIEF.md
# Injected Discontinuous Sequence Stepper

This block walks a short programmed list of injected channel codes and hands them one at a time to a converter. In stepping mode, each trigger converts exactly one list entry. The position is kept between triggers and returns to the first entry after the last one. In full-sequence mode, one trigger runs the whole list back to back.

For every conversion the block drives a start pulse and the channel code. It then waits for the converter's done handshake. After the done handshake it raises an end-of-conversion pulse. On the final entry it also raises an end-of-sequence pulse.

Stepping mode and automatic injection are mutually exclusive. If both are requested, the block flags an illegal configuration and refuses triggers. Dropping the enable abandons any conversion in flight and returns the position to the first entry.

Top module: `inj_disc_stepper`

## Requirements
- R1: After reset, conv_start, conv_busy, eoc_pulse, eos_pulse and cfg_illegal are 0, and the position is entry 0.
- R2: With step_mode=1 and the block idle, a trigger sampled on one clock edge makes conv_start high for exactly the following cycle. conv_chan then shows the code of the current entry, where entry k sits in bits [5k+4:5k] of chan_list.
- R3: A conv_done sampled while busy makes eoc_pulse high for one cycle after that edge. If the entry was the last one, eos_pulse is high in the same cycle, and otherwise eos_pulse stays low.
- R4: A seq_len value of L selects L+1 entries (1 to 4). After the last entry is converted, the next conversion uses entry 0 again.
- R5: With step_mode=0, one trigger converts every entry in order. Each done launches the next entry in the cycle its eoc_pulse shows, and conv_busy drops after the last done.
- R6: A trigger that arrives while conv_busy is 1 is ignored. It launches no conversion, and the position does not change.
- R7: When step_mode and auto_inj are both 1, cfg_illegal reads 1 from the next cycle on, and triggers launch nothing. The position is held until the configuration is legal again.
- R8: While enable is 0, triggers are ignored and conv_busy is 0 from the next cycle. The next conversion after re-enabling uses entry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low clears position and aborts conversion |
| step_mode | input | 1 | 1: one entry per trigger; 0: whole list per trigger |
| auto_inj | input | 1 | Automatic injection request (used for the legality check) |
| seq_len | input | 2 | Number of entries minus one |
| chan_list | input | 20 | Four 5-bit channel codes, entry 0 in the low bits |
| trig | input | 1 | Injected trigger (one cycle) |
| conv_done | input | 1 | Converter finished the current conversion |
| conv_start | output | 1 | Start pulse to the converter |
| conv_chan | output | 5 | Channel code being converted |
| conv_busy | output | 1 | A conversion is outstanding |
| eoc_pulse | output | 1 | End of one conversion |
| eos_pulse | output | 1 | End of the programmed list |
| cfg_illegal | output | 1 | Stepping mode and automatic injection both set |

## Verification
On every cycle, the assertions check four things. An end-of-sequence pulse never appears without an end-of-conversion pulse. An end-of-conversion pulse always follows a done handshake that arrived while busy. A trigger in stepping mode cannot launch a conversion while one is outstanding or while the configuration is illegal. A low enable always clears the busy state.

Only the directed scenarios can show the following: the order of channel codes, the wrap after lists of one, three and four entries, back-to-back chaining in full-sequence mode, and the return to entry 0 after a disable. These depend on the programmed list and on the history of triggers.

// File: rtl/isds_pkg.sv
package isds_pkg;
  localparam int unsigned ISDS_ENTRIES = 4;
  localparam int unsigned ISDS_CHAN_W  = 5;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } isds_state_t;
endpackage

// File: rtl/isds_cfg_guard.sv
module isds_cfg_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic step_mode,
  input  logic auto_inj,
  output logic illegal_now,
  output logic illegal_q
);
  logic illegal_d;

  always_comb begin
    illegal_now = step_mode & auto_inj;
    illegal_d   = illegal_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) illegal_q <= 1'b0;
    else        illegal_q <= illegal_d;
  end
endmodule

// File: rtl/isds_position.sv
module isds_position #(
  parameter int unsigned ENTRIES = 4,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [IDX_W-1:0] last_idx,
  output logic [IDX_W-1:0] pos,
  output logic [IDX_W-1:0] pos_next,
  output logic             at_last
);
  logic [IDX_W-1:0] pos_d;
  logic             pos_en;

  always_comb begin
    at_last  = (pos == last_idx);
    pos_next = at_last ? '0 : pos + 1'b1;
    pos_en   = clear | advance;
    pos_d    = clear ? '0 : pos_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos <= '0;
    else if (pos_en) pos <= pos_d;
  end
endmodule

// File: rtl/isds_entry_mux.sv
module isds_entry_mux #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned CHAN_W  = 5,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES*CHAN_W-1:0] entries,
  input  logic [IDX_W-1:0]          idx,
  output logic [CHAN_W-1:0]         chan
);
  logic [CHAN_W-1:0] slot [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign slot[g] = entries[g*CHAN_W +: CHAN_W];
  end

  always_comb begin
    chan = slot[0];
    for (int i = 0; i < ENTRIES; i++) begin
      if (idx == IDX_W'(i)) chan = slot[i];
    end
  end
endmodule

// File: rtl/inj_disc_stepper.sv
module inj_disc_stepper
  import isds_pkg::*;
#(
  parameter int unsigned ENTRIES = ISDS_ENTRIES,
  parameter int unsigned CHAN_W  = ISDS_CHAN_W,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enable,
  input  logic                      step_mode,
  input  logic                      auto_inj,
  input  logic [IDX_W-1:0]          seq_len,
  input  logic [ENTRIES*CHAN_W-1:0] chan_list,
  input  logic                      trig,
  input  logic                      conv_done,
  output logic                      conv_start,
  output logic [CHAN_W-1:0]         conv_chan,
  output logic                      conv_busy,
  output logic                      eoc_pulse,
  output logic                      eos_pulse,
  output logic                      cfg_illegal
);
  isds_state_t       state_q, state_d;
  logic              illegal_now;
  logic [IDX_W-1:0]  pos, pos_next, mux_idx;
  logic              at_last;
  logic              done_evt, launch, chain;
  logic              start_d, eoc_d, eos_d;
  logic [CHAN_W-1:0] chan_sel, chan_d;
  logic              chan_en;

  isds_cfg_guard u_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_mode   (step_mode),
    .auto_inj    (auto_inj),
    .illegal_now (illegal_now),
    .illegal_q   (cfg_illegal)
  );

  isds_position #(.ENTRIES(ENTRIES)) u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (~enable),
    .advance  (done_evt),
    .last_idx (seq_len),
    .pos      (pos),
    .pos_next (pos_next),
    .at_last  (at_last)
  );

  isds_entry_mux #(.ENTRIES(ENTRIES), .CHAN_W(CHAN_W)) u_mux (
    .entries (chan_list),
    .idx     (mux_idx),
    .chan    (chan_sel)
  );

  // Next-state logic
  always_comb begin
    done_evt = enable & (state_q == ST_CONV) & conv_done;
    launch   = enable & (state_q == ST_IDLE) & trig & ~illegal_now;
    chain    = done_evt & ~step_mode & ~at_last;
    mux_idx  = done_evt ? pos_next : pos;
    start_d  = launch | chain;
    eoc_d    = done_evt;
    eos_d    = done_evt & at_last;
    chan_en  = start_d;
    chan_d   = chan_sel;

    state_d = state_q;
    if (!enable)       state_d = ST_IDLE;
    else if (done_evt) state_d = chain ? ST_CONV : ST_IDLE;
    else if (launch)   state_d = ST_CONV;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      conv_start <= 1'b0;
      eoc_pulse  <= 1'b0;
      eos_pulse  <= 1'b0;
    end else begin
      state_q    <= state_d;
      conv_start <= start_d;
      eoc_pulse  <= eoc_d;
      eos_pulse  <= eos_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       conv_chan <= '0;
    else if (chan_en) conv_chan <= chan_d;
  end

  assign conv_busy = (state_q == ST_CONV);
endmodule

// File: rtl/isds_checker.sv
module isds_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic step_mode,
  input logic auto_inj,
  input logic trig,
  input logic conv_done,
  input logic conv_start,
  input logic conv_busy,
  input logic eoc_pulse,
  input logic eos_pulse
);
  AST_EOS_NEEDS_EOC: assert property (@(posedge clk) disable iff (!rst_n)
    eos_pulse |-> eoc_pulse); // R3

  AST_EOC_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_pulse |-> $past(conv_done && conv_busy && enable)); // R3

  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_busy && !conv_done && step_mode) |=> !conv_start); // R6

  AST_NO_START_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (step_mode && auto_inj && !conv_busy) |=> !conv_start); // R7

  AST_DISABLE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!conv_busy && !conv_start)); // R8
endmodule

bind inj_disc_stepper isds_checker u_isds_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .step_mode  (step_mode),
  .auto_inj   (auto_inj),
  .trig       (trig),
  .conv_done  (conv_done),
  .conv_start (conv_start),
  .conv_busy  (conv_busy),
  .eoc_pulse  (eoc_pulse),
  .eos_pulse  (eos_pulse)
);

// File: tb/tb_inj_disc_stepper.sv
module tb_inj_disc_stepper;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable, step_mode, auto_inj, trig, conv_done;
  logic [1:0]  seq_len;
  logic [19:0] chan_list;
  logic        conv_start, conv_busy, eoc_pulse, eos_pulse, cfg_illegal;
  logic [4:0]  conv_chan;
  int unsigned n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  inj_disc_stepper dut (.*);

  task automatic chk(input int unsigned act, input int unsigned exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Pulse trigger; check start and code one cycle later
  task automatic fire(input bit exp_start, input int unsigned exp_code, input string tag);
    trig = 1'b1; step(); trig = 1'b0;
    chk(conv_start, exp_start, {tag, " start"});
    if (exp_start) chk(conv_chan, exp_code, {tag, " chan"});
  endtask

  // Pulse done; check end pulses
  task automatic finish(input bit exp_eos, input string tag);
    conv_done = 1'b1; step(); conv_done = 1'b0;
    chk(eoc_pulse, 1, {tag, " eoc"});
    chk(eos_pulse, exp_eos, {tag, " eos"});
  endtask

  function automatic logic [19:0] pack(input int a, input int b, input int c, input int d);
    return {5'(d), 5'(c), 5'(b), 5'(a)};
  endfunction

  task automatic t_reset();
    chk(conv_start, 0, "R1 start");
    chk(conv_busy, 0, "R1 busy");
    chk(eoc_pulse | eos_pulse, 0, "R1 pulses");
    chk(cfg_illegal, 0, "R1 illegal");
  endtask

  task automatic t_three_step();
    seq_len = 2; chan_list = pack(7, 12, 31, 3); step_mode = 1;
    fire(1, 7, "R2 e0");  finish(0, "R3 e0");
    fire(1, 12, "R2 e1"); finish(0, "R3 e1");
    fire(1, 31, "R2 e2"); finish(1, "R3 e2");
    fire(1, 7, "R4 wrap3"); finish(0, "R4 wrap3");
    step(); chk(eoc_pulse, 0, "R3 eoc one cycle");
    // restore position to 0: convert e1, e2
    fire(1, 12, "R2 e1b"); finish(0, "R3 e1b");
    fire(1, 31, "R2 e2b"); finish(1, "R3 e2b");
  endtask

  task automatic t_single();
    seq_len = 0; chan_list = pack(19, 1, 2, 3);
    fire(1, 19, "R4 len1 a"); finish(1, "R4 len1 a");
    fire(1, 19, "R4 len1 b"); finish(1, "R4 len1 b");
  endtask

  task automatic t_four();
    seq_len = 3; chan_list = pack(4, 9, 22, 30);
    fire(1, 4, "R4 len4 e0");  finish(0, "R4 len4 e0");
    fire(1, 9, "R4 len4 e1");  finish(0, "R4 len4 e1");
    fire(1, 22, "R4 len4 e2"); finish(0, "R4 len4 e2");
    fire(1, 30, "R4 len4 e3"); finish(1, "R4 len4 e3");
    fire(1, 4, "R4 len4 wrap"); finish(0, "R4 len4 wrap");
  endtask

  task automatic t_busy_trig();
    // position now 1 (entry 9)
    fire(1, 9, "R6 first");
    fire(0, 0, "R6 busy trig");
    chk(conv_busy, 1, "R6 still busy");
    finish(0, "R6 done");
    fire(1, 22, "R6 position unchanged"); finish(0, "R6 done2");
    fire(1, 30, "R6 e3"); finish(1, "R6 e3");
  endtask

  task automatic t_full();
    step_mode = 0; seq_len = 2; chan_list = pack(5, 6, 8, 0);
    fire(1, 5, "R5 e0");
    conv_done = 1'b1; step(); conv_done = 1'b0;
    chk(eoc_pulse, 1, "R5 eoc0"); chk(conv_start, 1, "R5 chain1");
    chk(conv_chan, 6, "R5 chan1"); chk(conv_busy, 1, "R5 busy1");
    conv_done = 1'b1; step(); conv_done = 1'b0;
    chk(conv_start, 1, "R5 chain2"); chk(conv_chan, 8, "R5 chan2");
    chk(eos_pulse, 0, "R5 no eos mid");
    finish(1, "R5 last");
    chk(conv_busy, 0, "R5 idle after last");
    chk(conv_start, 0, "R5 no extra start");
    step_mode = 1;
  endtask

  task automatic t_illegal();
    seq_len = 2; chan_list = pack(7, 12, 31, 3);
    fire(1, 7, "R7 pre"); finish(0, "R7 pre");
    auto_inj = 1; step();
    chk(cfg_illegal, 1, "R7 flag");
    fire(0, 0, "R7 blocked");
    chk(conv_busy, 0, "R7 idle");
    auto_inj = 0; step();
    chk(cfg_illegal, 0, "R7 flag clear");
    fire(1, 12, "R7 position held"); finish(0, "R7 post");
  endtask

  task automatic t_disable();
    fire(1, 31, "R8 busy");
    enable = 0; step();
    chk(conv_busy, 0, "R8 abort");
    fire(0, 0, "R8 ignored");
    enable = 1; step();
    fire(1, 7, "R8 back to e0"); finish(0, "R8 post");
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; enable = 1; step_mode = 1; auto_inj = 0; trig = 0; conv_done = 0;
    seq_len = 0; chan_list = '0;
    step(); step();
    t_reset();
    rst_n = 1; step();
    t_reset();
    t_three_step();
    t_single();
    t_four();
    t_busy_trig();
    t_full();
    t_illegal();
    t_disable();
    step();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule